// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state for a small set of interrupt sources and decides when each source offers an interrupt to a downstream presentation unit. Each source is typed once as level-signalled or message-signalled. It holds a target server number, a priority, a saved priority and a handful of status bits. Those status bits record the line state, an offer in flight, an offer that was refused and an event that arrived while masked. The all-ones priority value masks a source.

The presentation unit returns three kinds of notification: a refusal of an offer, an end-of-interrupt, and a request to sweep all sources again. Source numbers on the offer port and on the refusal and end-of-interrupt inputs are global: the local index plus a parameterised base. The default base is 4096, so local source 2 is global number 4098. A single registered offer port carries the number, the server and the priority. When more than one source is waiting, the lowest local index goes first. The resend sweep visits one source per clock.

A synchronous clear returns every source to the masked, idle state but keeps its type. The asynchronous reset also forgets the types.

Top module: `irq_src_ctrl`

## Requirements
- R1: After the asynchronous reset, every source is untyped and masked, and no offer is valid. After `clr_i`, every source has priority and saved priority all-ones, server 0 and all status bits cleared, and no offer is valid. The type of each source is kept.
- R2: A source with no type ignores line events, configuration writes, refusals, end-of-interrupts and resend sweeps, and it never produces an offer.
- R3: A message source treats each clock with its line high as one event. While masked (priority all-ones), an event sets masked-pending and produces no offer. While unmasked, each event produces one offer.
- R4: A level source samples its line on every change. When unmasked, asserted and not yet sent, it marks itself sent and produces exactly one offer. A line that stays high gives no further offer.
- R5: A refusal whose number is in range marks a message source as rejected and clears the sent bit of a level source. A refusal outside [BASE, BASE+NSRC) has no effect.
- R6: An end-of-interrupt clears the sent bit of a level source. On a message source it has no effect. Numbers outside the range are ignored.
- R7: `resend_i` starts a sweep from local index 0 and visits one source per clock. A rejected message source has its rejected bit cleared and is re-offered if unmasked. A level source is re-offered if unmasked, asserted and not sent. The sweep does not advance while an offer is waiting for `offer_ready_i`.
- R8: A configuration write to a typed source replaces its server, priority and saved priority. A masked-pending message source that the write unmasks clears masked-pending and is offered. A level source re-applies the asserted-and-not-sent rule with the new priority.
- R9: An offer stays valid with stable number, server and priority until accepted. Among waiting sources the lowest local index is taken. The offer number is BASE plus the local index, and the server and priority are the source's values when the offer is loaded.
- R10: The type of a source can be set only once. A later type write to the same source is ignored until the asynchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low, also clears types |
| clr_i | input | 1 | Synchronous clear of all source state except the type |
| type_we_i | input | 1 | Type write strobe |
| type_idx_i | input | IDXW | Local index for the type write |
| type_level_i | input | 1 | 1 = level source, 0 = message source |
| src_line_i | input | NSRC | Per-source input lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDXW | Local index for the configuration write |
| cfg_server_i | input | SRVW | New target server |
| cfg_prio_i | input | PRIOW | New priority (all-ones masks) |
| cfg_saved_i | input | PRIOW | New saved priority |
| rej_valid_i | input | 1 | Refusal notification strobe |
| rej_num_i | input | NUMW | Global number of the refused source |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_num_i | input | NUMW | Global number of the finished source |
| resend_i | input | 1 | Start a resend sweep |
| offer_valid_o | output | 1 | Offer present |
| offer_ready_i | input | 1 | Offer accepted this clock |
| offer_num_o | output | NUMW | Global source number of the offer |
| offer_server_o | output | SRVW | Target server of the offer |
| offer_prio_o | output | PRIOW | Priority of the offer |

## Verification
The in-RTL assertions watch, on every clock, the things that hold at all times:
- each source type uses only its own status bits;
- an untyped source stays idle;
- the type never changes once set;
- a waiting offer holds still;
- the sweep pointer freezes during a stall;
- the clear leaves sources masked and idle.

Only the bench scenarios can show the retry sequences that connect several operations over time. These are a refused level or message source coming back through a sweep, an end-of-interrupt reopening a level source, and unmasking releasing a held message event. The scenarios also cover the lowest-index ordering under back-pressure, the range filter on incoming numbers, and the fact that the type survives the clear. The behavioural reference model in the bench is compared with the offer port on every clock to catch timing differences.

// File: rtl/isc_pkg.sv
package isc_pkg;
   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_LEVEL = 2'd1,
      KIND_MSG   = 2'd2
   } src_kind_e;
endpackage

// File: rtl/isc_src_slot.sv
module isc_src_slot
   import isc_pkg::*;
#(
   parameter int SRVW  = 8,
   parameter int PRIOW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             type_we_i,
   input  logic             type_level_i,
   input  logic             line_i,
   input  logic             cfg_we_i,
   input  logic [SRVW-1:0]  cfg_server_i,
   input  logic [PRIOW-1:0] cfg_prio_i,
   input  logic [PRIOW-1:0] cfg_saved_i,
   input  logic             rej_hit_i,
   input  logic             eoi_hit_i,
   input  logic             scan_hit_i,
   input  logic             grant_i,
   output logic             queued_o,
   output logic [SRVW-1:0]  server_o,
   output logic [PRIOW-1:0] prio_o
);
   localparam logic [PRIOW-1:0] MASKP = '1;

   src_kind_e        kind_q,  kind_d;
   logic [SRVW-1:0]  srv_q,   srv_d;
   logic [PRIOW-1:0] prio_q,  prio_d;
   logic [PRIOW-1:0] saved_q, saved_d;
   logic asrt_q, asrt_d, sent_q, sent_d, rej_q, rej_d, mpend_q, mpend_d, que_q, que_d;

   always_comb begin
      kind_d  = kind_q;  srv_d   = srv_q;   prio_d = prio_q; saved_d = saved_q;
      asrt_d  = asrt_q;  sent_d  = sent_q;  rej_d  = rej_q;  mpend_d = mpend_q;
      que_d   = que_q;
      if (grant_i) que_d = 1'b0;
      if (type_we_i && kind_q == KIND_NONE)
         kind_d = type_level_i ? KIND_LEVEL : KIND_MSG;
      // line events
      if (kind_q == KIND_MSG) begin
         if (line_i) begin
            if (prio_q == MASKP) mpend_d = 1'b1;
            else                 que_d   = 1'b1;
         end
      end else if (kind_q == KIND_LEVEL && line_i != asrt_q) begin
         asrt_d = line_i;
         if (prio_q != MASKP && asrt_d && !sent_d) begin
            sent_d = 1'b1; que_d = 1'b1;
         end
      end
      // configuration write
      if (cfg_we_i && kind_q != KIND_NONE) begin
         srv_d = cfg_server_i; prio_d = cfg_prio_i; saved_d = cfg_saved_i;
         if (kind_q == KIND_MSG && mpend_d && prio_d != MASKP) begin
            mpend_d = 1'b0; que_d = 1'b1;
         end
         if (kind_q == KIND_LEVEL && prio_d != MASKP && asrt_d && !sent_d) begin
            sent_d = 1'b1; que_d = 1'b1;
         end
      end
      // refusal
      if (rej_hit_i) begin
         if (kind_q == KIND_MSG)        rej_d  = 1'b1;
         else if (kind_q == KIND_LEVEL) sent_d = 1'b0;
      end
      // end of interrupt
      if (eoi_hit_i && kind_q == KIND_LEVEL) sent_d = 1'b0;
      // resend sweep visit
      if (scan_hit_i) begin
         if (kind_q == KIND_MSG && rej_d) begin
            rej_d = 1'b0;
            if (prio_d != MASKP) que_d = 1'b1;
         end else if (kind_q == KIND_LEVEL && prio_d != MASKP && asrt_d && !sent_d) begin
            sent_d = 1'b1; que_d = 1'b1;
         end
      end
      if (clr_i) begin
         kind_d = kind_q; srv_d = '0; prio_d = MASKP; saved_d = MASKP;
         asrt_d = 1'b0; sent_d = 1'b0; rej_d = 1'b0; mpend_d = 1'b0; que_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= KIND_NONE; srv_q <= '0; prio_q <= MASKP; saved_q <= MASKP;
         asrt_q <= 1'b0; sent_q <= 1'b0; rej_q <= 1'b0; mpend_q <= 1'b0; que_q <= 1'b0;
      end else begin
         kind_q <= kind_d; srv_q <= srv_d; prio_q <= prio_d; saved_q <= saved_d;
         asrt_q <= asrt_d; sent_q <= sent_d; rej_q <= rej_d; mpend_q <= mpend_d; que_q <= que_d;
      end
   end

   assign queued_o = que_q;
   assign server_o = srv_q;
   assign prio_o   = prio_q;

   AST_UNTYPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      kind_q == KIND_NONE |-> !que_q && !asrt_q && !sent_q && !rej_q && !mpend_q); // R2
   AST_MSG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      kind_q == KIND_MSG |-> !asrt_q && !sent_q); // R3
   AST_LEVEL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      kind_q == KIND_LEVEL |-> !rej_q && !mpend_q); // R4
   AST_TYPE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      kind_q != KIND_NONE |=> kind_q == $past(kind_q)); // R10
   AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_i) |-> prio_q == MASKP && saved_q == MASKP && !que_q && !sent_q && !rej_q && !mpend_q); // R1
endmodule

// File: rtl/isc_offer_arb.sv
module isc_offer_arb #(
   parameter int NSRC  = 8,
   parameter int NUMW  = 16,
   parameter int BASE  = 4096,
   parameter int SRVW  = 8,
   parameter int PRIOW = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr_i,
   input  logic [NSRC-1:0]             queued_i,
   input  logic [NSRC-1:0][SRVW-1:0]   server_i,
   input  logic [NSRC-1:0][PRIOW-1:0]  prio_i,
   input  logic                        offer_ready_i,
   output logic [NSRC-1:0]             grant_o,
   output logic                        stall_o,
   output logic                        offer_valid_o,
   output logic [NUMW-1:0]             offer_num_o,
   output logic [SRVW-1:0]             offer_server_o,
   output logic [PRIOW-1:0]            offer_prio_o
);
   localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;
   localparam logic [NUMW-1:0] BASE_N = NUMW'(BASE);

   logic            port_free;
   logic            win_found;
   logic [IDXW-1:0] win_idx;

   assign port_free = !offer_valid_o || offer_ready_i;
   assign stall_o   = !port_free;

   always_comb begin
      win_found = 1'b0;
      win_idx   = '0;
      for (int k = NSRC - 1; k >= 0; k--) begin
         if (queued_i[k]) begin
            win_found = 1'b1;
            win_idx   = IDXW'(k);
         end
      end
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_grant
      assign grant_o[g] = port_free && win_found && !clr_i && (win_idx == IDXW'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offer_valid_o  <= 1'b0;
         offer_num_o    <= '0;
         offer_server_o <= '0;
         offer_prio_o   <= '0;
      end else if (clr_i) begin
         offer_valid_o  <= 1'b0;
      end else if (port_free) begin
         offer_valid_o <= win_found;
         if (win_found) begin
            offer_num_o    <= BASE_N + NUMW'(win_idx);
            offer_server_o <= server_i[win_idx];
            offer_prio_o   <= prio_i[win_idx];
         end
      end
   end

   AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      offer_valid_o && !offer_ready_i && !clr_i |=> offer_valid_o && $stable(offer_num_o)
         && $stable(offer_server_o) && $stable(offer_prio_o)); // R9
   AST_OFFER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      offer_valid_o |-> offer_num_o >= BASE_N && offer_num_o < BASE_N + NUMW'(NSRC)); // R9
endmodule

// File: rtl/isc_resend_scan.sv
module isc_resend_scan #(
   parameter int NSRC = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            start_i,
   input  logic            stall_i,
   output logic [NSRC-1:0] hit_o
);
   localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;
   localparam logic [IDXW-1:0] LAST = IDXW'(NSRC - 1);

   logic            active_q;
   logic [IDXW-1:0] ptr_q;
   logic            step;

   assign step = active_q && !stall_i && !start_i && !clr_i;

   for (genvar g = 0; g < NSRC; g++) begin : g_hit
      assign hit_o[g] = step && (ptr_q == IDXW'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ptr_q    <= '0;
      end else if (clr_i) begin
         active_q <= 1'b0;
         ptr_q    <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         ptr_q    <= '0;
      end else if (step) begin
         if (ptr_q == LAST) active_q <= 1'b0;
         else               ptr_q    <= ptr_q + 1'b1;
      end
   end

   AST_SCAN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      active_q && stall_i && !start_i && !clr_i |=> active_q && $stable(ptr_q)); // R7
   AST_SCAN_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !clr_i |=> active_q && ptr_q == '0); // R7
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl #(
   parameter int NSRC  = 8,
   parameter int NUMW  = 16,
   parameter int BASE  = 4096,
   parameter int SRVW  = 8,
   parameter int PRIOW = 8,
   localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             type_we_i,
   input  logic [IDXW-1:0]  type_idx_i,
   input  logic             type_level_i,
   input  logic [NSRC-1:0]  src_line_i,
   input  logic             cfg_we_i,
   input  logic [IDXW-1:0]  cfg_idx_i,
   input  logic [SRVW-1:0]  cfg_server_i,
   input  logic [PRIOW-1:0] cfg_prio_i,
   input  logic [PRIOW-1:0] cfg_saved_i,
   input  logic             rej_valid_i,
   input  logic [NUMW-1:0]  rej_num_i,
   input  logic             eoi_valid_i,
   input  logic [NUMW-1:0]  eoi_num_i,
   input  logic             resend_i,
   output logic             offer_valid_o,
   input  logic             offer_ready_i,
   output logic [NUMW-1:0]  offer_num_o,
   output logic [SRVW-1:0]  offer_server_o,
   output logic [PRIOW-1:0] offer_prio_o
);
   localparam logic [NUMW-1:0] BASE_N = NUMW'(BASE);
   localparam logic [NUMW-1:0] NSRC_N = NUMW'(NSRC);

   initial begin
      assert (NSRC >= 2 && NUMW > IDXW && BASE + NSRC <= 2 ** NUMW && PRIOW >= 1 && SRVW >= 1)
         else $error("irq_src_ctrl: parameter set out of range");
   end

   logic [NUMW-1:0] rej_off, eoi_off;
   logic            rej_in, eoi_in;
   logic [NSRC-1:0] rej_hit, eoi_hit, scan_hit, grant, queued;
   logic [NSRC-1:0][SRVW-1:0]  slot_srv;
   logic [NSRC-1:0][PRIOW-1:0] slot_prio;
   logic            stall;

   // global number to local index, with range filter
   assign rej_off = rej_num_i - BASE_N;
   assign eoi_off = eoi_num_i - BASE_N;
   assign rej_in  = rej_valid_i && (rej_num_i >= BASE_N) && (rej_off < NSRC_N);
   assign eoi_in  = eoi_valid_i && (eoi_num_i >= BASE_N) && (eoi_off < NSRC_N);

   for (genvar i = 0; i < NSRC; i++) begin : g_slot
      assign rej_hit[i] = rej_in && (rej_off[IDXW-1:0] == IDXW'(i));
      assign eoi_hit[i] = eoi_in && (eoi_off[IDXW-1:0] == IDXW'(i));

      isc_src_slot #(.SRVW(SRVW), .PRIOW(PRIOW)) u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .clr_i        (clr_i),
         .type_we_i    (type_we_i && (type_idx_i == IDXW'(i))),
         .type_level_i (type_level_i),
         .line_i       (src_line_i[i]),
         .cfg_we_i     (cfg_we_i && (cfg_idx_i == IDXW'(i))),
         .cfg_server_i (cfg_server_i),
         .cfg_prio_i   (cfg_prio_i),
         .cfg_saved_i  (cfg_saved_i),
         .rej_hit_i    (rej_hit[i]),
         .eoi_hit_i    (eoi_hit[i]),
         .scan_hit_i   (scan_hit[i]),
         .grant_i      (grant[i]),
         .queued_o     (queued[i]),
         .server_o     (slot_srv[i]),
         .prio_o       (slot_prio[i])
      );
   end

   isc_offer_arb #(.NSRC(NSRC), .NUMW(NUMW), .BASE(BASE), .SRVW(SRVW), .PRIOW(PRIOW)) u_arb (
      .clk            (clk),
      .rst_n          (rst_n),
      .clr_i          (clr_i),
      .queued_i       (queued),
      .server_i       (slot_srv),
      .prio_i         (slot_prio),
      .offer_ready_i  (offer_ready_i),
      .grant_o        (grant),
      .stall_o        (stall),
      .offer_valid_o  (offer_valid_o),
      .offer_num_o    (offer_num_o),
      .offer_server_o (offer_server_o),
      .offer_prio_o   (offer_prio_o)
   );

   isc_resend_scan #(.NSRC(NSRC)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr_i),
      .start_i (resend_i),
      .stall_i (stall),
      .hit_o   (scan_hit)
   );

   AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !offer_valid_o); // R1
   AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rej_valid_i && rej_num_i < BASE_N |-> rej_hit == '0); // R5
endmodule

// File: tb/irq_src_ctrl_tb.sv
`timescale 1ns/1ps
module irq_src_ctrl_tb;
   localparam int N = 8;
   localparam int BASE = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 0, type_we = 0, type_level = 0, cfg_we = 0;
   logic [2:0] type_idx = '0, cfg_idx = '0;
   logic [N-1:0] line = '0;
   logic [7:0] cfg_srv = '0, cfg_prio = '0, cfg_saved = '0;
   logic rej_v = 0, eoi_v = 0, resend = 0, ready = 1;
   logic [15:0] rej_num = '0, eoi_num = '0;
   logic offer_valid;
   logic [15:0] offer_num;
   logic [7:0] offer_srv, offer_prio;

   int tests = 0, fails = 0;
   string cur_req = "R1";
   bit done = 0;

   always #2 clk = ~clk;

   irq_src_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .clr_i(clr),
      .type_we_i(type_we), .type_idx_i(type_idx), .type_level_i(type_level),
      .src_line_i(line),
      .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_server_i(cfg_srv),
      .cfg_prio_i(cfg_prio), .cfg_saved_i(cfg_saved),
      .rej_valid_i(rej_v), .rej_num_i(rej_num),
      .eoi_valid_i(eoi_v), .eoi_num_i(eoi_num),
      .resend_i(resend),
      .offer_valid_o(offer_valid), .offer_ready_i(ready),
      .offer_num_o(offer_num), .offer_server_o(offer_srv), .offer_prio_o(offer_prio)
   );

   // behavioural reference model: kind 0 none, 1 level, 2 message
   int mk[N], ms[N], mp[N], msv[N];
   bit ma[N], mse[N], mr[N], mm[N], mq[N];
   bit mov, mact, m_free, m_step;
   int mnum, msrvo, mprio, mptr, m_win, m_wsrv, m_wprio, m_newk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            mk[i] = 0; ms[i] = 0; mp[i] = 255; msv[i] = 255;
            ma[i] = 0; mse[i] = 0; mr[i] = 0; mm[i] = 0; mq[i] = 0;
         end
         mov = 0; mnum = 0; msrvo = 0; mprio = 0; mact = 0; mptr = 0;
      end else begin
         m_free = !mov || ready;
         m_step = mact && m_free && !resend && !clr;
         m_win = -1;
         for (int k = 0; k < N; k++) if (mq[k] && m_win < 0) m_win = k;
         if (m_win >= 0) begin m_wsrv = ms[m_win]; m_wprio = mp[m_win]; end
         if (clr) begin
            for (int i = 0; i < N; i++) begin
               ms[i] = 0; mp[i] = 255; msv[i] = 255;
               ma[i] = 0; mse[i] = 0; mr[i] = 0; mm[i] = 0; mq[i] = 0;
            end
            mov = 0; mact = 0; mptr = 0;
         end else begin
            for (int i = 0; i < N; i++) begin
               m_newk = mk[i];
               if (m_free && m_win == i) mq[i] = 0;
               if (type_we && type_idx == i && mk[i] == 0) m_newk = type_level ? 1 : 2;
               if (mk[i] == 2 && line[i]) begin
                  if (mp[i] == 255) mm[i] = 1; else mq[i] = 1;
               end else if (mk[i] == 1 && line[i] != ma[i]) begin
                  ma[i] = line[i];
                  if (mp[i] != 255 && ma[i] && !mse[i]) begin mse[i] = 1; mq[i] = 1; end
               end
               if (cfg_we && cfg_idx == i && mk[i] != 0) begin
                  ms[i] = cfg_srv; mp[i] = cfg_prio; msv[i] = cfg_saved;
                  if (mk[i] == 2 && mm[i] && mp[i] != 255) begin mm[i] = 0; mq[i] = 1; end
                  if (mk[i] == 1 && mp[i] != 255 && ma[i] && !mse[i]) begin mse[i] = 1; mq[i] = 1; end
               end
               if (rej_v && rej_num == BASE + i) begin
                  if (mk[i] == 2) mr[i] = 1; else if (mk[i] == 1) mse[i] = 0;
               end
               if (eoi_v && eoi_num == BASE + i && mk[i] == 1) mse[i] = 0;
               if (m_step && mptr == i) begin
                  if (mk[i] == 2 && mr[i]) begin
                     mr[i] = 0; if (mp[i] != 255) mq[i] = 1;
                  end else if (mk[i] == 1 && mp[i] != 255 && ma[i] && !mse[i]) begin
                     mse[i] = 1; mq[i] = 1;
                  end
               end
               mk[i] = m_newk;
            end
            if (m_free) begin
               mov = (m_win >= 0);
               if (m_win >= 0) begin mnum = BASE + m_win; msrvo = m_wsrv; mprio = m_wprio; end
            end
            if (resend) begin mact = 1; mptr = 0; end
            else if (m_step) begin
               if (mptr == N - 1) mact = 0; else mptr = mptr + 1;
            end
         end
      end
   end

   // per-clock comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         tests++;
         if (offer_valid !== mov) begin
            fails++;
            $display("FAIL %s: offer_valid=%0d expected %0d", cur_req, offer_valid, mov);
         end else if (mov && (offer_num !== 16'(mnum) || offer_srv !== 8'(msrvo) || offer_prio !== 8'(mprio))) begin
            fails++;
            $display("FAIL %s: offer num/srv/prio=%0d/%0d/%0d expected %0d/%0d/%0d",
                     cur_req, offer_num, offer_srv, offer_prio, mnum, msrvo, mprio);
         end
      end
   end

   task automatic tick(); @(negedge clk); endtask

   task automatic set_type(input int idx, input bit lvl);
      tick(); type_we = 1; type_idx = 3'(idx); type_level = lvl;
      tick(); type_we = 0;
   endtask

   task automatic cfg(input int idx, input int srv, input int prio);
      tick(); cfg_we = 1; cfg_idx = 3'(idx); cfg_srv = 8'(srv); cfg_prio = 8'(prio); cfg_saved = 8'(prio);
      tick(); cfg_we = 0;
   endtask

   task automatic pulse(input int idx);
      tick(); line[idx] = 1;
      tick(); line[idx] = 0;
   endtask

   task automatic refuse(input int num);
      tick(); rej_v = 1; rej_num = 16'(num);
      tick(); rej_v = 0;
   endtask

   task automatic finish_irq(input int num);
      tick(); eoi_v = 1; eoi_num = 16'(num);
      tick(); eoi_v = 0;
   endtask

   task automatic sweep();
      tick(); resend = 1;
      tick(); resend = 0;
   endtask

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic see_offer(input int num, input int prio, input string req);
      bit got = 0;
      for (int c = 0; c < 40 && !got; c++) begin
         tick();
         if (offer_valid) got = 1;
      end
      check(got, req, "offer appeared", got, 1);
      if (got) begin
         check(offer_num == 16'(num), req, "offer number", offer_num, num);
         check(offer_prio == 8'(prio), req, "offer priority", offer_prio, prio);
      end
   endtask

   task automatic no_offer(input int cycles, input string req);
      int seen = 0;
      for (int c = 0; c < cycles; c++) begin
         tick();
         if (offer_valid) seen++;
      end
      check(seen == 0, req, "unexpected offers", seen, 0);
   endtask

   initial begin
      #800000;
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      rst_n = 1;
      cur_req = "R1";
      tick();
      check(offer_valid == 0, "R1", "offer valid after reset", offer_valid, 0);

      // types: 0 msg, 1 level, 2 msg, 3 level, 7 left untyped
      cur_req = "R10";
      set_type(0, 0); set_type(1, 1); set_type(2, 0); set_type(3, 1);
      set_type(0, 1);                         // second write must be ignored (R10)

      cur_req = "R3";
      pulse(0);                               // masked: held as pending
      no_offer(5, "R3");
      cur_req = "R8";
      cfg(0, 3, 5);                           // unmask releases the held event
      see_offer(BASE + 0, 5, "R8");
      check(offer_srv == 8'd3, "R8", "offer server", offer_srv, 3);
      cur_req = "R3";
      pulse(0);
      see_offer(BASE + 0, 5, "R3");

      // R10: message behaviour kept, three high clocks give three offers
      cur_req = "R10";
      tick(); line[0] = 1;
      cnt = 0;
      for (int c = 0; c < 3; c++) begin tick(); if (offer_valid) cnt++; end
      line[0] = 0;
      for (int c = 0; c < 5; c++) begin tick(); if (offer_valid) cnt++; end
      check(cnt == 3, "R10", "offers from three high clocks", cnt, 3);

      // level source
      cur_req = "R4";
      cfg(1, 2, 7);
      no_offer(4, "R4");
      tick(); line[1] = 1;
      see_offer(BASE + 1, 7, "R4");
      no_offer(6, "R4");                      // line held: no repeat
      cur_req = "R5";
      refuse(BASE + 1);
      no_offer(4, "R5");
      cur_req = "R7";
      sweep();
      see_offer(BASE + 1, 7, "R7");
      cur_req = "R6";
      finish_irq(BASE + 1);
      sweep();
      see_offer(BASE + 1, 7, "R6");
      cur_req = "R5";
      refuse(BASE + N + 1);                   // out of range: sent stays set
      refuse(BASE - 1);
      sweep();
      no_offer(14, "R5");
      cur_req = "R6";
      finish_irq(BASE + 9);                   // out of range
      sweep();
      no_offer(14, "R6");
      tick(); line[1] = 0;
      finish_irq(BASE + 1);
      sweep();
      no_offer(14, "R4");

      // message refusal and retry
      cur_req = "R5";
      pulse(0);
      see_offer(BASE + 0, 5, "R5");
      refuse(BASE + 0);
      cur_req = "R7";
      sweep();
      see_offer(BASE + 0, 5, "R7");
      sweep();
      no_offer(14, "R7");
      cur_req = "R6";
      finish_irq(BASE + 0);
      sweep();
      no_offer(14, "R6");

      // untyped source
      cur_req = "R2";
      pulse(7);
      cfg(7, 1, 1);
      pulse(7);
      refuse(BASE + 7);
      sweep();
      no_offer(14, "R2");

      // arbitration and hold under back-pressure
      cur_req = "R9";
      cfg(2, 9, 3);
      tick(); ready = 0; line[0] = 1; line[2] = 1;
      tick(); line[0] = 0; line[2] = 0;
      tick(); tick();
      check(offer_valid && offer_num == 16'(BASE), "R9", "lowest index first", offer_num, BASE);
      repeat (3) begin
         tick();
         check(offer_valid && offer_num == 16'(BASE), "R9", "offer held", offer_num, BASE);
      end
      ready = 1;
      tick();
      check(offer_valid && offer_num == 16'(BASE + 2) && offer_srv == 8'd9, "R9",
            "second offer", offer_num, BASE + 2);
      no_offer(4, "R9");

      // sweep stall: two rejected message sources, port held busy
      cur_req = "R7";
      refuse(BASE + 0); refuse(BASE + 2);
      pulse(0);
      tick(); ready = 0;
      sweep();
      repeat (6) tick();
      ready = 1;
      repeat (16) tick();

      // synchronous clear keeps types
      cur_req = "R1";
      tick(); clr = 1;
      tick(); clr = 0;
      check(offer_valid == 0, "R1", "offer valid after clear", offer_valid, 0);
      pulse(0);
      no_offer(4, "R1");
      cfg(0, 4, 6);
      see_offer(BASE + 0, 6, "R1");
      tick(); line[3] = 1;
      cfg(3, 1, 2);
      see_offer(BASE + 3, 2, "R8");
      tick(); line[3] = 0;
      repeat (6) tick();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule